// File: doc/BRIEF.md
# Line-Scan Frame Assembler

This block sits right after the deserialiser of a line-scan grayscale camera. The camera sends lines without end and gives no frame-valid signal. The block groups a fixed number of consecutive lines into a 2-D frame that a frame buffer can store. Each cycle it sees the camera pixel clock, an 8-bit grayscale pixel, a line-valid qualifier and a data-valid qualifier. A pixel is taken only when both qualifiers are high. For every pixel taken, the block registers the pixel and raises a write strobe. Beside the pixel it gives the column index, the line index within the frame, and a linear write address into a frame-sized buffer.

A small state machine follows line activity. ST_SYNC is the state after reset; the block ignores all traffic there. On a line-valid rising edge the machine moves from ST_SYNC to ST_LINE. When line-valid goes low it moves from ST_LINE to ST_GAP. The next rising edge takes it from ST_GAP back to ST_LINE. Every rising edge opens a new line and clears the column count. After the last line of a frame, the line index wraps to zero.

The block raises start-of-frame with the first pixel of line 0 and end-of-frame with the last pixel of the last line. It has two sticky error flags. One reports a line that closed before it was full. The other reports a line that carried more pixels than a line can hold. Frame geometry is set by parameters: 1024 pixels per line and 80 lines per frame by default.

Top module: `linescan_framer`

## Requirements
- R1: The write strobe is raised for a pixel only if line-valid and data-valid were both high in the cycle the pixel was presented. It is never raised in state ST_SYNC without a rising edge.
- R2: Every output that goes with a pixel appears exactly one clock after the pixel is presented. These are the pixel, the strobe, the column, the line, the address, start-of-frame and end-of-frame.
- R3: The column index is 0 for the first pixel taken after a line-valid rising edge. It rises by one for each further pixel taken in the same line.
- R4: The line index becomes 0 at the first rising edge after reset. It rises by one at each later rising edge and wraps from FRAME_LINES-1 (default 79) to 0.
- R5: The write address equals line index × LINE_PIX + column index (LINE_PIX defaults to 1024). After the last pixel of a frame it returns to 0.
- R6: The pixel output holds the last pixel taken. The asynchronous active-low reset clears it to 0.
- R7: Start-of-frame is high for one cycle, together with the pixel at line 0, column 0. End-of-frame is high for one cycle, together with the pixel at line FRAME_LINES-1, column LINE_PIX-1.
- R8: A line that ends with fewer than LINE_PIX pixels taken still counts as a line. It sets the short-line flag, which stays high until reset.
- R9: Pixels beyond LINE_PIX in one line produce no write, and the column count stays at its limit. They set the overflow flag, which stays high until reset.
- R10: After reset, data is ignored until the first line-valid rising edge. If line-valid is already high when reset is released, that does not count as a rising edge.
- R11: While reset is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Camera pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | PIX_W | Incoming grayscale pixel |
| line_vld | input | 1 | High while a line is being transmitted |
| data_vld | input | 1 | High when pix_in carries a pixel |
| pix_out | output | PIX_W | Last pixel taken, registered |
| wr_en | output | 1 | Write strobe for pix_out |
| col_idx | output | $clog2(LINE_PIX) | Column of the written pixel |
| line_idx | output | $clog2(FRAME_LINES) | Line within the frame of the written pixel |
| wr_addr | output | $clog2(LINE_PIX*FRAME_LINES) | Linear frame-buffer address |
| sof | output | 1 | Start-of-frame pulse |
| eof | output | 1 | End-of-frame pulse |
| short_err | output | 1 | Sticky flag: a line ended before it was full |
| col_ovf | output | 1 | Sticky flag: a line carried too many pixels |

## Verification
A wrong column counter shows up in col_idx and wr_addr on the very next write strobe. A wrong line counter or a missed rising edge shows up at the first pixel of the following line, because the index and the address jump there. A stuck or late state machine either produces writes in the first cycle of a line that should have been ignored, or drops a whole line. The bench sees either one within a cycle. A short-line flag set one line late, or never, shows up on the cycle after line-valid falls. Start-of-frame and end-of-frame mistakes show up at the frame boundary, which the bench crosses many times with random line lengths and gaps.

// File: rtl/lsf_pkg.sv
`timescale 1ns/1ps
package lsf_pkg;
    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_LINE = 2'd1,
        ST_GAP  = 2'd2
    } lsf_state_e;
endpackage

// File: rtl/lsf_edge_detect.sv
`timescale 1ns/1ps
module lsf_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_vld,
    output logic rise
);
    logic vld_q;

    // Reset to 1: a line already active at reset release is not a rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b1;
        else        vld_q <= line_vld;
    end

    assign rise = line_vld & ~vld_q;
endmodule

// File: rtl/lsf_line_fsm.sv
`timescale 1ns/1ps
module lsf_line_fsm
    import lsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_vld,
    input  logic rise,
    output logic first_line,
    output logic in_window,
    output logic line_end
);
    lsf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC: if (rise)      state_d = ST_LINE;
            ST_LINE: if (!line_vld) state_d = ST_GAP;
            ST_GAP:  if (rise)      state_d = ST_LINE;
            default:                state_d = ST_SYNC;
        endcase
    end

    always_comb begin
        first_line = 1'b0;
        in_window  = rise;
        line_end   = 1'b0;
        unique case (state_q)
            ST_SYNC: first_line = 1'b1;
            ST_LINE: begin
                in_window = 1'b1;
                line_end  = ~line_vld;
            end
            ST_GAP:  ;
            default: ;
        endcase
    end
endmodule

// File: rtl/lsf_pos_counters.sv
`timescale 1ns/1ps
module lsf_pos_counters #(
    parameter int FRAME_LINES = 80,
    parameter int CNT_W       = 11,
    parameter int LINE_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              first_line,
    input  logic              accept,
    output logic [CNT_W-1:0]  col_eff,
    output logic [LINE_W-1:0] line_eff
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);

    logic [CNT_W-1:0]  col_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_next;

    assign line_next = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
    assign line_eff  = line_start ? (first_line ? '0 : line_next) : line_q;
    assign col_eff   = line_start ? '0 : col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            line_q <= '0;
        end else begin
            line_q <= line_eff;
            col_q  <= accept ? col_eff + 1'b1 : col_eff;
        end
    end
endmodule

// File: rtl/linescan_framer.sv
`timescale 1ns/1ps
module linescan_framer #(
    parameter int PIX_W       = 8,
    parameter int LINE_PIX    = 1024,
    parameter int FRAME_LINES = 80
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [PIX_W-1:0]                        pix_in,
    input  logic                                    line_vld,
    input  logic                                    data_vld,
    output logic [PIX_W-1:0]                        pix_out,
    output logic                                    wr_en,
    output logic [$clog2(LINE_PIX)-1:0]             col_idx,
    output logic [$clog2(FRAME_LINES)-1:0]          line_idx,
    output logic [$clog2(LINE_PIX*FRAME_LINES)-1:0] wr_addr,
    output logic                                    sof,
    output logic                                    eof,
    output logic                                    short_err,
    output logic                                    col_ovf
);
    localparam int CNT_W  = $clog2(LINE_PIX + 1);
    localparam int COL_W  = $clog2(LINE_PIX);
    localparam int LINE_W = $clog2(FRAME_LINES);
    localparam int ADDR_W = $clog2(LINE_PIX * FRAME_LINES);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(LINE_PIX);
    localparam logic [CNT_W-1:0]  LAST_COL  = CNT_W'(LINE_PIX - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);
    localparam bit POW2_LINE = ((LINE_PIX & (LINE_PIX - 1)) == 0);

    logic              rise, first_line, in_window, line_end;
    logic [CNT_W-1:0]  col_eff;
    logic [LINE_W-1:0] line_eff;
    logic              offered, accept, ovf_hit, short_hit, sof_d, eof_d;
    logic [ADDR_W-1:0] addr_d;

    lsf_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_vld (line_vld),
        .rise     (rise)
    );

    lsf_line_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_vld   (line_vld),
        .rise       (rise),
        .first_line (first_line),
        .in_window  (in_window),
        .line_end   (line_end)
    );

    lsf_pos_counters #(
        .FRAME_LINES (FRAME_LINES),
        .CNT_W       (CNT_W),
        .LINE_W      (LINE_W)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (rise),
        .first_line (first_line),
        .accept     (accept),
        .col_eff    (col_eff),
        .line_eff   (line_eff)
    );

    assign offered   = line_vld & data_vld & in_window;
    assign accept    = offered & (col_eff < FULL_CNT);
    assign ovf_hit   = offered & (col_eff == FULL_CNT);
    assign short_hit = line_end & (col_eff < FULL_CNT);
    assign sof_d     = accept & (col_eff == '0) & (line_eff == '0);
    assign eof_d     = accept & (col_eff == LAST_COL) & (line_eff == LAST_LINE);

    // Address build: plain concatenation for a power-of-two line, multiply otherwise
    generate
        if (POW2_LINE) begin : g_addr_cat
            assign addr_d = ADDR_W'({line_eff, col_eff[COL_W-1:0]});
        end else begin : g_addr_mul
            assign addr_d = ADDR_W'(line_eff) * ADDR_W'(LINE_PIX) + ADDR_W'(col_eff);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_out   <= '0;
            wr_en     <= 1'b0;
            col_idx   <= '0;
            line_idx  <= '0;
            wr_addr   <= '0;
            sof       <= 1'b0;
            eof       <= 1'b0;
            short_err <= 1'b0;
            col_ovf   <= 1'b0;
        end else begin
            wr_en     <= accept;
            sof       <= sof_d;
            eof       <= eof_d;
            short_err <= short_err | short_hit;
            col_ovf   <= col_ovf | ovf_hit;
            if (accept) begin
                pix_out  <= pix_in;
                col_idx  <= col_eff[COL_W-1:0];
                line_idx <= line_eff;
                wr_addr  <= addr_d;
            end
        end
    end
endmodule

// File: rtl/lsf_checker.sv
`timescale 1ns/1ps
module lsf_checker #(
    parameter int PIX_W       = 8,
    parameter int LINE_PIX    = 1024,
    parameter int FRAME_LINES = 80
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               line_vld,
    input logic                               data_vld,
    input logic [PIX_W-1:0]                   pix_out,
    input logic                               wr_en,
    input logic [$clog2(LINE_PIX)-1:0]        col_idx,
    input logic [$clog2(FRAME_LINES)-1:0]     line_idx,
    input logic                               sof,
    input logic                               eof,
    input logic                               short_err,
    input logic                               col_ovf
);
    localparam int COL_W  = $clog2(LINE_PIX);
    localparam int LINE_W = $clog2(FRAME_LINES);

    a_r1_strobe_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(line_vld) && $past(data_vld)));

    a_r3_column_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |->
            (line_idx == $past(line_idx) && col_idx == COL_W'($past(col_idx) + 1'b1)));

    a_r6_pixel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> $stable(pix_out));

    a_r7_sof_position: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (wr_en && col_idx == '0 && line_idx == '0));

    a_r7_eof_position: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> (wr_en && col_idx == COL_W'(LINE_PIX - 1)
                       && line_idx == LINE_W'(FRAME_LINES - 1)));

    a_r7_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sof, eof}));

    a_r8_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(short_err) |-> short_err);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(col_ovf) |-> col_ovf);
endmodule

bind linescan_framer lsf_checker #(
    .PIX_W       (PIX_W),
    .LINE_PIX    (LINE_PIX),
    .FRAME_LINES (FRAME_LINES)
) u_lsf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_vld  (line_vld),
    .data_vld  (data_vld),
    .pix_out   (pix_out),
    .wr_en     (wr_en),
    .col_idx   (col_idx),
    .line_idx  (line_idx),
    .sof       (sof),
    .eof       (eof),
    .short_err (short_err),
    .col_ovf   (col_ovf)
);

// File: tb/test_linescan_framer.sv
`timescale 1ns/1ps
module test_linescan_framer;
    localparam int PIX_W = 8;
    localparam int LP    = 16;
    localparam int FL    = 3;
    localparam int COL_W  = $clog2(LP);
    localparam int LINE_W = $clog2(FL);
    localparam int ADDR_W = $clog2(LP * FL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PIX_W-1:0]  pix_in = '0;
    logic              line_vld = 1'b0;
    logic              data_vld = 1'b0;
    logic [PIX_W-1:0]  pix_out;
    logic              wr_en, sof, eof, short_err, col_ovf;
    logic [COL_W-1:0]  col_idx;
    logic [LINE_W-1:0] line_idx;
    logic [ADDR_W-1:0] wr_addr;

    always #4 clk = ~clk;

    linescan_framer #(.PIX_W(PIX_W), .LINE_PIX(LP), .FRAME_LINES(FL)) i_linescan_framer (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .line_vld(line_vld), .data_vld(data_vld),
        .pix_out(pix_out), .wr_en(wr_en), .col_idx(col_idx), .line_idx(line_idx),
        .wr_addr(wr_addr), .sof(sof), .eof(eof), .short_err(short_err), .col_ovf(col_ovf)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string wr_tag = "R1 R2";

    // reference model state
    int m_lprev, m_sync, m_inl, m_col, m_line;
    int e_we, e_pix, e_col, e_line, e_addr, e_sof, e_eof, e_short, e_ovf;

    function automatic void cmp(string req, string sig, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, sig, act, exp);
        end
    endfunction

    function automatic void model_reset();
        m_lprev = 1; m_sync = 0; m_inl = 0; m_col = 0; m_line = 0;
        e_we = 0; e_pix = 0; e_col = 0; e_line = 0; e_addr = 0;
        e_sof = 0; e_eof = 0; e_short = 0; e_ovf = 0;
    endfunction

    function automatic void model_cycle(int lv, int dv, int px);
        int rise;
        rise = (lv != 0 && m_lprev == 0) ? 1 : 0;
        e_we = 0; e_sof = 0; e_eof = 0;
        if (lv == 0 && m_inl != 0) begin
            if (m_col < LP) e_short = 1;
            m_inl = 0;
        end
        if (rise != 0) begin
            if (m_sync == 0) begin m_line = 0; m_sync = 1; end
            else m_line = (m_line == FL - 1) ? 0 : m_line + 1;
            m_col = 0;
            m_inl = 1;
        end
        if (lv != 0 && dv != 0 && m_inl != 0) begin
            if (m_col < LP) begin
                e_we = 1; e_pix = px; e_col = m_col; e_line = m_line;
                e_addr = m_line * LP + m_col;
                e_sof = (m_line == 0 && m_col == 0) ? 1 : 0;
                e_eof = (m_line == FL - 1 && m_col == LP - 1) ? 1 : 0;
                m_col++;
            end else begin
                e_ovf = 1;
            end
        end
        m_lprev = lv;
    endfunction

    function automatic void check_outputs();
        string t;
        t = (rst_n == 1'b0) ? "R11" : "";
        cmp({t, " ", wr_tag}, "wr_en", int'(wr_en), e_we);
        cmp({t, " R7"}, "sof", int'(sof), e_sof);
        cmp({t, " R7"}, "eof", int'(eof), e_eof);
        cmp({t, " R6"}, "pix_out", int'(pix_out), e_pix);
        cmp({t, " R8"}, "short_err", int'(short_err), e_short);
        cmp({t, " R9"}, "col_ovf", int'(col_ovf), e_ovf);
        if (e_we != 0) begin
            cmp("R3", "col_idx", int'(col_idx), e_col);
            cmp("R4", "line_idx", int'(line_idx), e_line);
            cmp("R5", "wr_addr", int'(wr_addr), e_addr);
        end
    endfunction

    task automatic step(input int lv, input int dv, input int px, input int rs);
        @(negedge clk);
        check_outputs();
        rst_n    = rs[0];
        line_vld = lv[0];
        data_vld = dv[0];
        pix_in   = px[PIX_W-1:0];
        if (rs == 0) model_reset();
        else model_cycle(lv, dv, px);
    endtask

    // one line: line-valid high until n data-valid cycles were sent, then a gap
    task automatic send_line(input int n, input int dens, input int gap);
        int sent = 0;
        while (sent < n) begin
            int dv = (($urandom % 100) < dens) ? 1 : 0;
            step(1, dv, $urandom % 256, 1);
            sent += dv;
        end
        if (n == 0) step(1, 0, 0, 1);
        for (int g = 0; g < gap; g++) step(0, $urandom % 2, $urandom % 256, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // R11: outputs stay 0 while reset is held, even with live traffic
        for (int i = 0; i < 3; i++) step(1, 1, 8'hA5, 0);
        // R10: release while line-valid is high; nothing may be written
        wr_tag = "R10";
        for (int i = 0; i < 6; i++) step(1, 1, i + 1, 1);
        step(0, 1, 8'h11, 1);
        step(0, 0, 0, 1);
        wr_tag = "R1 R2";
        // directed full frame with dense data (R3 R4 R5 R7)
        for (int l = 0; l < FL; l++) send_line(LP, 100, 2);
        // second frame with sparse data, wrap of line index and address
        for (int l = 0; l < FL; l++) send_line(LP, 40, 3);
        // R8 short line, then R9 overflow line
        send_line(LP - 5, 80, 2);
        send_line(LP + 4, 90, 2);
        // mid-run reset clears sticky flags (R11 then R10)
        step(1, 1, 8'h3C, 0);
        step(1, 1, 8'h3C, 0);
        step(1, 0, 0, 1);
        step(0, 0, 0, 1);
        // empty line counts as a short line (R8)
        send_line(0, 50, 2);
        for (int l = 0; l < FL - 1; l++) send_line(LP, 70, 1);
        // constrained random lines
        for (int l = 0; l < 300; l++) begin
            int r = $urandom % 100;
            int n = (r < 80) ? LP : (r < 90) ? ($urandom % LP) : (LP + 1 + $urandom % 4);
            send_line(n, 30 + $urandom % 71, 1 + $urandom % 4);
            if (l == 150) begin
                step(0, 0, 0, 0);
                step(0, 0, 0, 1);
            end
        end
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule